// File: doc/BRIEF.md
# PCI Main-Memory Target Termination Controller

This block is the target-side handshake engine of a 32-bit PCI port that sits in front of main memory. It samples the bus master's framing, initiator-ready and lock signals together with an external memory-select decode. It then drives the three target responses: device select, target ready and stop. It decides whether a transaction is claimed at all, inserts wait states, and ends a transaction early when needed. A retry ends it when memory is locked by another master. A disconnect ends it when a read burst reaches the end of a cache line, or when a write dword fills one of the posted-write buffers.

All bus signals are modelled active-high: a 1 on a port means the bus line is asserted. The posted-write buffers are modelled only as fill counters. A separate drain pulse, produced by whatever empties them into memory, frees the oldest full buffer. The address port carries only the dword index within the cache line (bus address bits [4:2] for the default 8-dword line).

Top module: `pci_mem_target`

## Requirements
- R1: Out of reset, and whenever no transaction is in progress, devsel_o, trdy_o and stop_o are all 0.
- R2: A transaction is claimed (devsel_o = 1 in the cycle after the address phase) only if memsel_i is 1 at the address-phase edge. If it is 0, devsel_o, trdy_o and stop_o stay 0 until frame_i and irdy_i are both sampled 0. trdy_o and stop_o are never 1 while devsel_o is 0.
- R3: A data phase completes on each rising edge where irdy_i and trdy_o are both 1. Any other cycle is a wait state, and the burst index and buffer fill do not advance.
- R4: If the address phase samples memsel_i, lock_i and mem_locked_i all at 1, the next cycle shows devsel_o = 1, stop_o = 1 and trdy_o = 0, and no data phase follows. lock_i without mem_locked_i gives a normal claim.
- R5: A read burst offers dwords with trdy_o = 1 from index addr_i upward. The dword at index LINE_DW-1 is offered with stop_o = 1 as well, so a read starting at index k moves at most LINE_DW-k dwords.
- R6: Once stop_o is 1 it stays 1 while frame_i is sampled 1. It returns to 0 the cycle after frame_i is sampled 0.
- R7: Write dwords go into NBUF buffers of BUF_DW dwords each, one buffer after another. The dword that makes a buffer full is offered with trdy_o = 1 and stop_o = 1.
- R8: When every buffer is full, a write holds trdy_o = 0 (wait states) until drain_i frees one. Each drain_i pulse frees the oldest full buffer and has no effect if none is full.
- R9: On the edge where frame_i and irdy_i are both sampled 0, devsel_o, trdy_o and stop_o all go to 0 for the next cycle.
- R10: A data phase that completes with frame_i = 0 is the last one. trdy_o is 0 from the next cycle.
- R11: A drain_i pulse and a write dword accepted on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Master frame (1 = asserted) |
| irdy_i | input | 1 | Master initiator ready |
| lock_i | input | 1 | Master lock request seen in the address phase |
| mem_locked_i | input | 1 | Main memory is locked by a different master |
| memsel_i | input | 1 | External decode: address lies in main memory |
| wr_cmd_i | input | 1 | Command is a memory write (0 = read), valid in the address phase |
| addr_i | input | IDX_W | Dword index within the cache line, valid in the address phase |
| drain_i | input | 1 | One-cycle pulse: the oldest full write buffer has been emptied |
| devsel_o | output | 1 | Device select |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Stop request (retry or disconnect) |

## Verification
The delicate coincidence is a drain pulse that frees a full buffer on the very edge where a write dword lands in the other buffer. The bench provokes it by raising drain_i during the first accepted dword of a write burst, when one buffer is already full. A behavioural model compares all three outputs every cycle. The burst that follows must then move exactly BUF_DW dwords before its disconnect, which shows that both the fill and the freeing took effect.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_END   = 2'd2,
        ST_OTHER = 2'd3
    } pmt_state_e;

    typedef struct packed {
        pmt_state_e st;
        logic       devsel;
        logic       trdy;
        logic       stop;
        logic       wr;
    } pmt_ctl_s;

endpackage

// File: rtl/pmt_line_ctr.sv
module pmt_line_ctr #(
    parameter  int LINE_DW = 8,
    localparam int IDX_W   = $clog2(LINE_DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] load_idx_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_nx_o,
    output logic             last_nx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_DW - 1);

    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        idx_d = idx_q;
        if (load_i)
            idx_d = load_idx_i;
        else if (step_i)
            idx_d = idx_q + 1'b1;
        idx_nx_o  = idx_d;
        last_nx_o = (idx_d == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else
            idx_q <= idx_d;
    end

endmodule

// File: rtl/pmt_wbuf.sv
module pmt_wbuf #(
    parameter int NBUF   = 2,
    parameter int BUF_DW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic drain_i,
    output logic room_nx_o,
    output logic fill_last_nx_o
);
    localparam int PW = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int CW = $clog2(BUF_DW + 1);
    localparam logic [CW-1:0] FULL      = CW'(BUF_DW);
    localparam logic [CW-1:0] ONE_SHORT = CW'(BUF_DW - 1);
    localparam logic [PW-1:0] LAST_PTR  = PW'(NBUF - 1);

    logic [CW-1:0] cnt_q [NBUF];
    logic [CW-1:0] cnt_d [NBUF];
    logic [PW-1:0] wsel_q, wsel_d;
    logic [PW-1:0] rsel_q, rsel_d;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cnt_d  = cnt_q;
        wsel_d = wsel_q;
        rsel_d = rsel_q;
        if (drain_i && cnt_q[rsel_q] == FULL) begin
            cnt_d[rsel_q] = '0;
            rsel_d        = ptr_next(rsel_q);
        end
        if (push_i && cnt_q[wsel_q] != FULL) begin
            cnt_d[wsel_q] = cnt_q[wsel_q] + 1'b1;
            if (cnt_q[wsel_q] == ONE_SHORT)
                wsel_d = ptr_next(wsel_q);
        end
        room_nx_o      = (cnt_d[wsel_d] != FULL);
        fill_last_nx_o = (cnt_d[wsel_d] == ONE_SHORT);
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[g] <= '0;
            else
                cnt_q[g] <= cnt_d[g];
        end

        a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g] <= FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel_q <= '0;
            rsel_q <= '0;
        end else begin
            wsel_q <= wsel_d;
            rsel_q <= rsel_d;
        end
    end

    // R8: the control logic must never accept a dword while the fill target is full
    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q[wsel_q] != FULL));

endmodule

// File: rtl/pci_mem_target.sv
module pci_mem_target #(
    parameter  int LINE_DW = 8,
    parameter  int BUF_DW  = 4,
    parameter  int NBUF    = 2,
    localparam int IDX_W   = $clog2(LINE_DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             irdy_i,
    input  logic             lock_i,
    input  logic             mem_locked_i,
    input  logic             memsel_i,
    input  logic             wr_cmd_i,
    input  logic [IDX_W-1:0] addr_i,
    input  logic             drain_i,
    output logic             devsel_o,
    output logic             trdy_o,
    output logic             stop_o
);
    import pmt_pkg::*;

    pmt_ctl_s ctl_q, ctl_d;

    logic             done, addr_ph, release_c;
    logic             room_nx, fill_last_nx, last_nx;
    logic [IDX_W-1:0] idx_nx;
    logic             offer_wr, offer_trdy, offer_stop;

    assign done      = irdy_i & ctl_q.trdy;
    assign addr_ph   = (ctl_q.st == ST_IDLE) & frame_i;
    assign release_c = ~frame_i & ~irdy_i;

    pmt_line_ctr #(.LINE_DW(LINE_DW)) i_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (addr_ph & memsel_i),
        .load_idx_i (addr_i),
        .step_i     (done),
        .idx_nx_o   (idx_nx),
        .last_nx_o  (last_nx)
    );

    pmt_wbuf #(.NBUF(NBUF), .BUF_DW(BUF_DW)) i_wbuf (
        .clk            (clk),
        .rst_n          (rst_n),
        .push_i         (done & ctl_q.wr),
        .drain_i        (drain_i),
        .room_nx_o      (room_nx),
        .fill_last_nx_o (fill_last_nx)
    );

    always_comb begin
        offer_wr   = (ctl_q.st == ST_IDLE) ? wr_cmd_i : ctl_q.wr;
        offer_trdy = offer_wr ? room_nx : 1'b1;
        offer_stop = offer_wr ? (room_nx & fill_last_nx) : last_nx;
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (frame_i) begin
                    ctl_d.wr = wr_cmd_i;
                    if (!memsel_i) begin
                        ctl_d.st = ST_OTHER;
                    end else if (lock_i && mem_locked_i) begin
                        ctl_d.st     = ST_END;
                        ctl_d.devsel = 1'b1;
                        ctl_d.trdy   = 1'b0;
                        ctl_d.stop   = 1'b1;
                    end else begin
                        ctl_d.st     = ST_XFER;
                        ctl_d.devsel = 1'b1;
                        ctl_d.trdy   = offer_trdy;
                        ctl_d.stop   = offer_stop;
                    end
                end
            end
            ST_XFER: begin
                if (release_c) begin
                    ctl_d        = '0;
                    ctl_d.st     = ST_IDLE;
                end else if (done && (ctl_q.stop || !frame_i)) begin
                    ctl_d.st   = ST_END;
                    ctl_d.trdy = 1'b0;
                    ctl_d.stop = ctl_q.stop & frame_i;
                end else if (!ctl_q.stop) begin
                    ctl_d.trdy = offer_trdy;
                    ctl_d.stop = offer_stop;
                end
            end
            ST_END: begin
                if (release_c) begin
                    ctl_d    = '0;
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.stop = ctl_q.stop & frame_i;
                end
            end
            ST_OTHER: begin
                if (release_c) begin
                    ctl_d    = '0;
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign devsel_o = ctl_q.devsel;
    assign trdy_o   = ctl_q.trdy;
    assign stop_o   = ctl_q.stop;

    a_r2_claim_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_o) |-> $past(memsel_i));

    a_r2_resp_needs_devsel: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_o || stop_o) |-> devsel_o);

    a_r4_retry_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_o && frame_i && memsel_i && lock_i && mem_locked_i
         && ctl_q.st == ST_IDLE) |=> (devsel_o && stop_o && !trdy_o));

    a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && frame_i) |=> stop_o);

    a_r6_stop_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && !frame_i) |=> !stop_o);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_o && !frame_i && !irdy_i) |=> !(devsel_o || trdy_o || stop_o));

    a_r10_last_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_o && irdy_i && !frame_i) |=> !trdy_o);

endmodule

// File: tb/test_pci_mem_target.sv
`timescale 1ns/100ps
module test_pci_mem_target;

    localparam int LINE = 8;
    localparam int BUFW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame = 0, irdy = 0, lock = 0, mem_locked = 0, memsel = 1, wr_cmd = 0, drain = 0;
    logic [2:0] addr = '0;
    logic devsel_o, trdy_o, stop_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pci_mem_target i_pci_mem_target (
        .clk(clk), .rst_n(rst_n), .frame_i(frame), .irdy_i(irdy), .lock_i(lock),
        .mem_locked_i(mem_locked), .memsel_i(memsel), .wr_cmd_i(wr_cmd),
        .addr_i(addr), .drain_i(drain),
        .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_dev, m_trdy, m_stop, m_wr;
    int m_ph, m_idx, wp, rp;
    int fill [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dev = 0; m_trdy = 0; m_stop = 0; m_wr = 0;
            m_ph = 0; m_idx = 0; wp = 0; rp = 0; fill[0] = 0; fill[1] = 0;
        end else begin
            bit d, rel, ofw;
            d   = irdy && m_trdy;
            rel = !frame && !irdy;
            if (drain && fill[rp] == BUFW) begin fill[rp] = 0; rp = 1 - rp; end
            if (d && m_wr) begin
                fill[wp]++;
                if (fill[wp] == BUFW) wp = 1 - wp;
            end
            if (d) m_idx = (m_idx + 1) % LINE;
            ofw = 0;
            case (m_ph)
                0: if (frame) begin
                    m_wr = wr_cmd;
                    if (!memsel) m_ph = 3;
                    else if (lock && mem_locked) begin
                        m_ph = 2; m_dev = 1; m_stop = 1; m_trdy = 0;
                    end else begin
                        m_ph = 1; m_dev = 1; m_idx = int'(addr); ofw = 1;
                    end
                end
                1: if (rel) begin m_ph = 0; m_dev = 0; m_trdy = 0; m_stop = 0; end
                   else if (d && (m_stop || !frame)) begin
                       m_ph = 2; m_trdy = 0; m_stop = m_stop && frame;
                   end else if (!m_stop) ofw = 1;
                2: if (rel) begin m_ph = 0; m_dev = 0; m_trdy = 0; m_stop = 0; end
                   else m_stop = m_stop && frame;
                default: if (rel) m_ph = 0;
            endcase
            if (ofw) begin
                if (m_wr) begin
                    m_trdy = fill[wp] < BUFW;
                    m_stop = m_trdy && fill[wp] == BUFW - 1;
                end else begin
                    m_trdy = 1;
                    m_stop = (m_idx == LINE - 1);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(devsel_o == m_dev, "R2 devsel vs model", int'(devsel_o), int'(m_dev));
            chk(trdy_o == m_trdy,  "R3 trdy vs model",   int'(trdy_o),   int'(m_trdy));
            chk(stop_o == m_stop,  "R6 stop vs model",   int'(stop_o),   int'(m_stop));
        end
    end

    task automatic xact(input int a, input bit wr, input int n, input int wm,
                        output int got, output bit stp, output bit sawdev, output int waits);
        bit fin;
        int it;
        got = 0; stp = 0; sawdev = 0; waits = 0; fin = 0; it = 0;
        @(negedge clk);
        frame = 1; irdy = 0; addr = 3'(a >> 2); wr_cmd = wr;
        @(negedge clk);
        while (!fin) begin
            bit last;
            last  = (got >= n - 1) || stp;
            frame = !last;
            irdy  = (last || wm == 0) ? 1'b1 : ((it % wm) != 0);
            if (devsel_o) sawdev = 1;
            if (devsel_o && !trdy_o && !stop_o && irdy) waits++;
            if (irdy && trdy_o) got++;
            if (stop_o) stp = 1;
            if (!frame && ((irdy && trdy_o) || stop_o)) fin = 1;
            if (it > 60) fin = 1;
            it++;
            @(negedge clk);
        end
        frame = 0; irdy = 0;
        @(negedge clk);
    endtask

    task automatic pulse_drain();
        @(negedge clk); #1 drain = 1;
        @(negedge clk); #1 drain = 0;
    endtask

    initial begin
        int got, waits;
        bit stp, sd;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!devsel_o && !trdy_o && !stop_o, "R1 reset idle",
            int'({devsel_o, trdy_o, stop_o}), 0);

        // not our address
        memsel = 0;
        xact(32'h0, 0, 3, 0, got, stp, sd, waits);
        chk(!sd && got == 0, "R2 unselected ignored", int'(sd) + got, 0);
        memsel = 1;

        // reads
        xact(32'h14, 0, 10, 2, got, stp, sd, waits);
        chk(got == 3 && stp, "R5 read from index 5", got, 3);
        xact(32'h1C, 0, 4, 0, got, stp, sd, waits);
        chk(got == 1 && stp, "R5 read from last index", got, 1);
        xact(32'h00, 0, 3, 0, got, stp, sd, waits);
        chk(got == 3 && !stp, "R10 short read ends on frame", got, 3);
        xact(32'h00, 0, 8, 3, got, stp, sd, waits);
        chk(got == 8, "R3 read with irdy waits", got, 8);
        lock = 1;
        xact(32'h08, 0, 2, 0, got, stp, sd, waits);
        chk(got == 2 && !stp, "R4 lock without foreign lock claims", got, 2);

        // retry
        mem_locked = 1;
        xact(32'h00, 0, 4, 0, got, stp, sd, waits);
        chk(got == 0 && stp, "R4 retry moves no data", got, 0);

        // retry with stop held
        @(negedge clk); frame = 1; irdy = 0; wr_cmd = 0;
        @(negedge clk); irdy = 1;
        chk(devsel_o && stop_o && !trdy_o, "R4 retry response",
            int'({devsel_o, stop_o, trdy_o}), 6);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(stop_o == 1, "R6 stop held while frame", int'(stop_o), 1);
        end
        frame = 0;
        @(negedge clk);
        chk(stop_o == 0 && devsel_o == 1, "R6 stop drops after frame", int'(stop_o), 0);
        irdy = 0;
        @(negedge clk);
        chk(!devsel_o && !trdy_o && !stop_o, "R9 release", int'({devsel_o, trdy_o, stop_o}), 0);
        lock = 0; mem_locked = 0;

        // writes
        xact(32'h0, 1, 6, 0, got, stp, sd, waits);
        chk(got == BUFW && stp, "R7 disconnect on full buffer", got, BUFW);
        xact(32'h0, 1, 2, 0, got, stp, sd, waits);
        chk(got == 2 && !stp, "R7 partial fill of second buffer", got, 2);
        fork
            xact(32'h0, 1, 5, 0, got, stp, sd, waits);
            begin
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk); #1;
                    if (irdy && trdy_o) begin
                        drain = 1;
                        @(negedge clk); #1 drain = 0;
                        break;
                    end
                end
            end
        join
        chk(got == 2 && stp, "R11 fill with coincident drain", got, 2);
        xact(32'h0, 1, 6, 0, got, stp, sd, waits);
        chk(got == BUFW && stp, "R11 freed buffer reusable", got, BUFW);
        fork
            xact(32'h0, 1, 1, 0, got, stp, sd, waits);
            begin repeat (8) @(negedge clk); pulse_drain(); end
        join
        chk(waits >= 4, "R8 wait states while full", waits, 4);
        chk(got == 1, "R8 data after drain", got, 1);
        pulse_drain();
        repeat (3) @(negedge clk);
        chk(!devsel_o && !trdy_o && !stop_o, "R1 idle between transactions",
            int'({devsel_o, trdy_o, stop_o}), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule